// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block forms the byte a host sees when it reads a flash-style memory while an embedded program or erase is running. Outside such an operation it passes array data through unchanged. While one runs, the byte instead carries a data-poll bit, two toggle bits, a sticky pulse-limit bit and an erase-started bit. Host software uses these bits to find out whether the operation is still running, whether it has failed, and which sectors are involved.

The block follows decoded command writes. Each write arrives as a kind code plus a sector index. From these it tracks the operation phase in a small state machine. The states are READ (idle), PROG (program running), PROT (program aimed at a protected sector), WIN (sector-erase loading window), ERASE (erase running), SUSP (erase suspended) and SPROG (program during suspend).

The transitions are:
- READ goes to PROG, PROT, WIN or ERASE.
- PROG goes to READ on completion, or on a reset command after a limit failure.
- PROT goes to READ when its timer expires.
- WIN goes to ERASE on expiry, to SUSP on suspend, or to READ on any other command.
- ERASE goes to SUSP on suspend, or to READ on completion or a post-failure reset.
- SUSP goes to ERASE on resume, or to SPROG on an allowed program.
- SPROG goes back to SUSP on completion, or to READ on a post-failure reset.

The loading window is a retriggerable counter of `WIN_CYC` clocks. It lets further sector-erase commands queue sectors before the erase begins. The array and the real program/erase algorithms sit outside this block. They report back only through the `alg_done` and `alg_limit` pulses.

Top module: `op_status_gen`

## Requirements
- R1: After reset the block is in READ, `erase_run` is 0, and in READ `rd_data` equals `arr_data` in the same cycle.
- R2: A command with kind 0 (program) in READ, aimed at an unprotected sector, enters PROG and latches `cmd_d7`. In PROG and SPROG, `rd_data` is {~d7, T1, L, 5'b0}, where T1 is toggle bit 6 and L is the limit flag.
- R3: A command with kind 2 (chip erase) in READ selects every sector and enters ERASE at once, with no window. In ERASE, `erase_run` is 1 and `rd_data` is {0, T1, L, 0, 1, T2, 0, 0}.
- R4: Bit 6 (T1) inverts after every cycle with `rd_stb` high in PROG, PROT, WIN, ERASE and SPROG, whatever sector is read. It holds its value in SUSP and READ.
- R5: Bit 2 (T2) inverts after a cycle with `rd_stb` high in WIN, ERASE or SUSP only when `rd_sec` is a selected sector. Reads of unselected sectors leave it unchanged.
- R6: An `alg_limit` pulse in PROG, ERASE or SPROG sets bit 5. While bit 5 is set, `alg_done` is ignored. Only a command of kind 5 (reset) clears the flag and returns to READ, also clearing all sector selections.
- R7: A command with kind 1 (sector erase) in READ selects its sector and enters WIN, where bits 7 and 3 read 0. Each further kind-1 write in WIN adds its sector and restarts the window. After `WIN_CYC` cycles in WIN with no command, the state becomes ERASE.
- R8: In WIN, a command of kind 3 (suspend) moves to SUSP at once. Any kind other than 1 or 3 returns to READ and clears every selection.
- R9: In SUSP, reads of selected sectors return {1, T1, 0, 0, 0, T2, 0, 0} and reads of unselected sectors return `arr_data`. Kind 4 (resume) returns to ERASE. A program to an unselected, unprotected sector enters SPROG, which returns to SUSP on `alg_done`.
- R10: A program in READ to a sector whose `sec_prot` bit is set enters PROT. PROT shows program status with toggling bit 6 for `PROT_CYC` cycles and then returns to READ.
- R11: `alg_done` in PROG returns to READ. In ERASE it returns to READ and clears all selections.
- R12: In PROG and PROT every command is ignored, and in ERASE every command but suspend is ignored, unless the limit flag permits a reset. A suspend while the limit flag is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle strobe of a decoded command write |
| cmd_kind | input | 3 | Command kind: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 reset, 6/7 other |
| cmd_sec | input | SEC_BITS | Sector index carried by the command |
| cmd_d7 | input | 1 | Bit 7 of the byte being programmed |
| sec_prot | input | 2**SEC_BITS | Per-sector protection flags |
| alg_done | input | 1 | Embedded algorithm completion pulse |
| alg_limit | input | 1 | Embedded algorithm pulse-count limit exceeded |
| rd_stb | input | 1 | Host read cycle strobe |
| rd_sec | input | SEC_BITS | Sector index of the read address |
| arr_data | input | 8 | Array data for the read address |
| rd_data | output | 8 | Byte returned to the host |
| erase_run | output | 1 | High while the erase itself is running (ERASE state) |

## Verification
The bench drives each phase back to back and checks the byte on every cycle against a behavioural model. A window counter that is off by one, or that does not restart on a second sector-erase write, shifts the start of erase. That shows up as bit 3 or bit 7 changing one cycle early or late. Alternating reads of selected and unselected sectors expose a bit 2 that toggles on every read, and reads during suspend expose a bit 6 that keeps toggling. A limit failure followed by a completion pulse catches a design that lets `alg_done` end a failed operation, and aborting and suspending the window catch stale sector selections left behind.

// File: rtl/ost_pkg.sv
package ost_pkg;

    typedef enum logic [2:0] {
        CMD_PROG       = 3'd0,
        CMD_SECT_ERASE = 3'd1,
        CMD_CHIP_ERASE = 3'd2,
        CMD_SUSPEND    = 3'd3,
        CMD_RESUME     = 3'd4,
        CMD_RESET      = 3'd5,
        CMD_OTHER      = 3'd6,
        CMD_SPARE      = 3'd7
    } cmd_kind_t;

    typedef enum logic [2:0] {
        ST_READ      = 3'd0,
        ST_PROG      = 3'd1,
        ST_PROT      = 3'd2,
        ST_WIN       = 3'd3,
        ST_ERASE     = 3'd4,
        ST_SUSP      = 3'd5,
        ST_SUSP_PROG = 3'd6
    } state_t;

endpackage

// File: rtl/ost_cdown.sv
module ost_cdown #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(LEN - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && !load && (cnt_q == '0);
endmodule

// File: rtl/ost_sector_sel.sv
module ost_sector_sel #(
    parameter int SEC_BITS = 4,
    parameter int NSEC     = 1 << SEC_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add,
    input  logic                all,
    input  logic                clr,
    input  logic [SEC_BITS-1:0] cmd_sec,
    input  logic [SEC_BITS-1:0] rd_sec,
    output logic                cmd_hit,
    output logic                rd_hit
);
    logic [NSEC-1:0] sel_q;

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[g] <= 1'b0;
            end else if (clr) begin
                sel_q[g] <= 1'b0;
            end else if (all || (add && (cmd_sec == SEC_BITS'(g)))) begin
                sel_q[g] <= 1'b1;
            end
        end
    end

    assign cmd_hit = sel_q[cmd_sec];
    assign rd_hit  = sel_q[rd_sec];
endmodule

// File: rtl/ost_toggle_pair.sv
module ost_toggle_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic tog1_en,
    input  logic tog2_en,
    input  logic rd_hit,
    output logic t1_q,
    output logic t2_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t1_q <= 1'b0;
            t2_q <= 1'b0;
        end else begin
            if (rd_stb && tog1_en) begin
                t1_q <= ~t1_q;
            end
            if (rd_stb && tog2_en && rd_hit) begin
                t2_q <= ~t2_q;
            end
        end
    end
endmodule

// File: rtl/ost_seq_fsm.sv
module ost_seq_fsm
    import ost_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_stb,
    input  cmd_kind_t kind,
    input  logic      cmd_d7,
    input  logic      cmd_hit,
    input  logic      cmd_prot,
    input  logic      alg_done,
    input  logic      alg_limit,
    input  logic      win_exp,
    input  logic      prot_exp,
    output state_t    st,
    output logic      lim_q,
    output logic      pd7_q,
    output logic      load_win,
    output logic      load_prot,
    output logic      sel_add,
    output logic      sel_all,
    output logic      sel_clr,
    output logic      tog1_en,
    output logic      tog2_en,
    output logic      win_run,
    output logic      prot_run
);
    state_t nxt;
    logic   lat_pd, lim_set, lim_clr;
    logic   is_reset, is_susp;

    assign is_reset = cmd_stb && (kind == CMD_RESET) && lim_q;
    assign is_susp  = cmd_stb && (kind == CMD_SUSPEND) && !lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_READ;
            lim_q <= 1'b0;
            pd7_q <= 1'b0;
        end else begin
            st <= nxt;
            if (lim_clr) begin
                lim_q <= 1'b0;
            end else if (lim_set) begin
                lim_q <= 1'b1;
            end
            if (lat_pd) begin
                pd7_q <= cmd_d7;
            end
        end
    end

    always_comb begin
        nxt       = st;
        load_win  = 1'b0;
        load_prot = 1'b0;
        sel_add   = 1'b0;
        sel_all   = 1'b0;
        sel_clr   = 1'b0;
        lat_pd    = 1'b0;
        lim_set   = 1'b0;
        lim_clr   = 1'b0;
        unique case (st)
            ST_READ: begin
                if (cmd_stb) begin
                    case (kind)
                        CMD_PROG: begin
                            lat_pd = 1'b1;
                            if (cmd_prot) begin
                                nxt       = ST_PROT;
                                load_prot = 1'b1;
                            end else begin
                                nxt = ST_PROG;
                            end
                        end
                        CMD_SECT_ERASE: begin
                            sel_add  = 1'b1;
                            load_win = 1'b1;
                            nxt      = ST_WIN;
                        end
                        CMD_CHIP_ERASE: begin
                            sel_all = 1'b1;
                            nxt     = ST_ERASE;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PROG: begin
                if (is_reset) begin
                    lim_clr = 1'b1;
                    nxt     = ST_READ;
                end else if (alg_limit) begin
                    lim_set = 1'b1;
                end else if (alg_done && !lim_q) begin
                    nxt = ST_READ;
                end
            end
            ST_PROT: begin
                if (prot_exp) begin
                    nxt = ST_READ;
                end
            end
            ST_WIN: begin
                if (cmd_stb) begin
                    if (kind == CMD_SECT_ERASE) begin
                        sel_add  = 1'b1;
                        load_win = 1'b1;
                    end else if (kind == CMD_SUSPEND) begin
                        nxt = ST_SUSP;
                    end else begin
                        sel_clr = 1'b1;
                        nxt     = ST_READ;
                    end
                end else if (win_exp) begin
                    nxt = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (is_reset) begin
                    lim_clr = 1'b1;
                    sel_clr = 1'b1;
                    nxt     = ST_READ;
                end else if (is_susp) begin
                    nxt = ST_SUSP;
                end else if (alg_limit) begin
                    lim_set = 1'b1;
                end else if (alg_done && !lim_q) begin
                    sel_clr = 1'b1;
                    nxt     = ST_READ;
                end
            end
            ST_SUSP: begin
                if (cmd_stb) begin
                    if (kind == CMD_RESUME) begin
                        nxt = ST_ERASE;
                    end else if ((kind == CMD_PROG) && !cmd_hit && !cmd_prot) begin
                        lat_pd = 1'b1;
                        nxt    = ST_SUSP_PROG;
                    end
                end
            end
            ST_SUSP_PROG: begin
                if (is_reset) begin
                    lim_clr = 1'b1;
                    sel_clr = 1'b1;
                    nxt     = ST_READ;
                end else if (alg_limit) begin
                    lim_set = 1'b1;
                end else if (alg_done && !lim_q) begin
                    nxt = ST_SUSP;
                end
            end
            default: nxt = ST_READ;
        endcase
    end

    always_comb begin
        tog1_en  = 1'b0;
        tog2_en  = 1'b0;
        win_run  = 1'b0;
        prot_run = 1'b0;
        unique case (st)
            ST_READ:      ;
            ST_PROG:      tog1_en = 1'b1;
            ST_PROT: begin
                tog1_en  = 1'b1;
                prot_run = 1'b1;
            end
            ST_WIN: begin
                tog1_en = 1'b1;
                tog2_en = 1'b1;
                win_run = 1'b1;
            end
            ST_ERASE: begin
                tog1_en = 1'b1;
                tog2_en = 1'b1;
            end
            ST_SUSP:      tog2_en = 1'b1;
            ST_SUSP_PROG: tog1_en = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/ost_read_mux.sv
module ost_read_mux
    import ost_pkg::*;
(
    input  state_t     st,
    input  logic [7:0] arr_data,
    input  logic       pd7_q,
    input  logic       lim_q,
    input  logic       t1_q,
    input  logic       t2_q,
    input  logic       rd_hit,
    output logic [7:0] rd_data
);
    always_comb begin
        unique case (st)
            ST_READ:                        rd_data = arr_data;
            ST_PROG, ST_PROT, ST_SUSP_PROG: rd_data = {~pd7_q, t1_q, lim_q, 5'b0};
            ST_WIN:                         rd_data = {1'b0, t1_q, lim_q, 2'b0, t2_q, 2'b0};
            ST_ERASE:                       rd_data = {1'b0, t1_q, lim_q, 1'b0, 1'b1, t2_q, 2'b0};
            ST_SUSP:                        rd_data = rd_hit ? {1'b1, t1_q, 3'b0, t2_q, 2'b0} : arr_data;
            default:                        rd_data = arr_data;
        endcase
    end
endmodule

// File: rtl/op_status_gen.sv
module op_status_gen
    import ost_pkg::*;
#(
    parameter int  SEC_BITS = 4,
    parameter int  WIN_CYC  = 6000,
    parameter int  PROT_CYC = 400,
    localparam int NSEC     = 1 << SEC_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_stb,
    input  logic [2:0]          cmd_kind,
    input  logic [SEC_BITS-1:0] cmd_sec,
    input  logic                cmd_d7,
    input  logic [NSEC-1:0]     sec_prot,
    input  logic                alg_done,
    input  logic                alg_limit,
    input  logic                rd_stb,
    input  logic [SEC_BITS-1:0] rd_sec,
    input  logic [7:0]          arr_data,
    output logic [7:0]          rd_data,
    output logic                erase_run
);
    state_t    st;
    cmd_kind_t kind;
    logic lim_q, pd7_q, load_win, load_prot, win_run, prot_run, win_exp, prot_exp;
    logic sel_add, sel_all, sel_clr, tog1_en, tog2_en, rd_hit, cmd_hit, cmd_prot;
    logic t1_q, t2_q;

    assign kind      = cmd_kind_t'(cmd_kind);
    assign cmd_prot  = sec_prot[cmd_sec];
    assign erase_run = (st == ST_ERASE);

    ost_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .kind(kind), .cmd_d7(cmd_d7),
        .cmd_hit(cmd_hit), .cmd_prot(cmd_prot), .alg_done(alg_done), .alg_limit(alg_limit),
        .win_exp(win_exp), .prot_exp(prot_exp), .st(st), .lim_q(lim_q), .pd7_q(pd7_q),
        .load_win(load_win), .load_prot(load_prot), .sel_add(sel_add), .sel_all(sel_all),
        .sel_clr(sel_clr), .tog1_en(tog1_en), .tog2_en(tog2_en), .win_run(win_run),
        .prot_run(prot_run)
    );

    ost_cdown #(.LEN(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .load(load_win), .run(win_run), .expire(win_exp)
    );

    ost_cdown #(.LEN(PROT_CYC)) u_prot (
        .clk(clk), .rst_n(rst_n), .load(load_prot), .run(prot_run), .expire(prot_exp)
    );

    ost_sector_sel #(.SEC_BITS(SEC_BITS), .NSEC(NSEC)) u_sel (
        .clk(clk), .rst_n(rst_n), .add(sel_add), .all(sel_all), .clr(sel_clr),
        .cmd_sec(cmd_sec), .rd_sec(rd_sec), .cmd_hit(cmd_hit), .rd_hit(rd_hit)
    );

    ost_toggle_pair u_tog (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .tog1_en(tog1_en), .tog2_en(tog2_en),
        .rd_hit(rd_hit), .t1_q(t1_q), .t2_q(t2_q)
    );

    ost_read_mux u_mux (
        .st(st), .arr_data(arr_data), .pd7_q(pd7_q), .lim_q(lim_q), .t1_q(t1_q),
        .t2_q(t2_q), .rd_hit(rd_hit), .rd_data(rd_data)
    );
endmodule

// File: rtl/op_status_gen_chk.sv
module op_status_gen_chk
    import ost_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_stb,
    input logic [2:0] cmd_kind,
    input logic       rd_stb,
    input logic [7:0] arr_data,
    input logic [7:0] rd_data,
    input logic       erase_run,
    input state_t     st,
    input logic       lim_q
);
    AST_READ_PASSES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ) |-> (rd_data == arr_data)); // R1

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        erase_run |-> (!rd_data[7] && rd_data[3])); // R3

    AST_TOG1_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && rd_stb && $past(erase_run && rd_stb)) |-> (rd_data[6] != $past(rd_data[6]))); // R4

    AST_LIMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q && !(cmd_stb && cmd_kind == 3'd5)) |=> lim_q); // R6

    AST_WINDOW_OPEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIN) |-> (!rd_data[3] && !rd_data[7])); // R7

    AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_run) |-> $past(st == ST_WIN || st == ST_READ || st == ST_SUSP)); // R7
endmodule

bind op_status_gen op_status_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .rd_stb(rd_stb),
    .arr_data(arr_data), .rd_data(rd_data), .erase_run(erase_run), .st(st), .lim_q(lim_q)
);

// File: tb/op_status_gen_tb.sv
`timescale 1ns/100ps
module op_status_gen_tb_top;
    localparam int SB = 4;
    localparam int NS = 1 << SB;
    localparam int WIN = 40;
    localparam int PROT = 8;
    localparam int K_PROG = 0, K_SE = 1, K_CE = 2, K_SUSP = 3, K_RES = 4, K_RST = 5, K_OTH = 6;
    localparam int M_READ = 0, M_PROG = 1, M_PROT = 2, M_WIN = 3, M_ERASE = 4, M_SUSP = 5, M_SPROG = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_stb = 1'b0;
    logic [2:0] cmd_kind = 3'd0;
    logic [SB-1:0] cmd_sec = '0;
    logic cmd_d7 = 1'b0;
    logic [NS-1:0] sec_prot = '0;
    logic alg_done = 1'b0, alg_limit = 1'b0, rd_stb = 1'b0;
    logic [SB-1:0] rd_sec = '0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;
    logic erase_run;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_st = M_READ;
    bit m_t1 = 0, m_t2 = 0, m_lim = 0, m_pd7 = 0;
    bit m_sel [NS];
    int m_win = 0, m_prot = 0;

    always #2.5 clk = ~clk;

    op_status_gen #(.SEC_BITS(SB), .WIN_CYC(WIN), .PROT_CYC(PROT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .cmd_sec(cmd_sec),
        .cmd_d7(cmd_d7), .sec_prot(sec_prot), .alg_done(alg_done), .alg_limit(alg_limit),
        .rd_stb(rd_stb), .rd_sec(rd_sec), .arr_data(arr_data), .rd_data(rd_data),
        .erase_run(erase_run)
    );

    function automatic logic [7:0] m_expect();
        case (m_st)
            M_READ:                 return arr_data;
            M_PROG, M_PROT, M_SPROG: return {~m_pd7, m_t1, m_lim, 5'b0};
            M_WIN:                  return {1'b0, m_t1, m_lim, 2'b0, m_t2, 2'b0};
            M_ERASE:                return {1'b0, m_t1, m_lim, 1'b0, 1'b1, m_t2, 2'b0};
            M_SUSP:                 return m_sel[int'(rd_sec)] ? {1'b1, m_t1, 3'b0, m_t2, 2'b0} : arr_data;
            default:                return arr_data;
        endcase
    endfunction

    function automatic string m_tag(logic [7:0] act, logic [7:0] exp);
        if (act[6] != exp[6]) return "R4";
        if (act[2] != exp[2]) return "R5";
        if (act[5] != exp[5]) return "R6";
        case (m_st)
            M_READ:  return "R1";
            M_PROG:  return "R2";
            M_PROT:  return "R10";
            M_WIN:   return "R7";
            M_ERASE: return "R3";
            default: return "R9";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] e;
            e = m_expect();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s state %0d rd_data actual %02h expected %02h", m_tag(rd_data, e), m_st, rd_data, e);
            end
            checks++;
            if (erase_run !== (m_st == M_ERASE)) begin
                errors++;
                $display("FAIL R3 erase_run actual %0b expected %0b", erase_run, (m_st == M_ERASE));
            end
        end
    end

    // behavioural model update
    always @(posedge clk) begin
        int s, c;
        bit is_rst;
        if (!rst_n) begin
            m_st = M_READ; m_t1 = 0; m_t2 = 0; m_lim = 0; m_pd7 = 0; m_win = 0; m_prot = 0;
            foreach (m_sel[i]) m_sel[i] = 0;
        end else begin
            s = int'(rd_sec);
            c = int'(cmd_sec);
            is_rst = cmd_stb && (int'(cmd_kind) == K_RST) && m_lim;
            if (rd_stb && (m_st == M_PROG || m_st == M_PROT || m_st == M_WIN || m_st == M_ERASE || m_st == M_SPROG))
                m_t1 = !m_t1;
            if (rd_stb && (m_st == M_WIN || m_st == M_ERASE || m_st == M_SUSP) && m_sel[s])
                m_t2 = !m_t2;
            case (m_st)
                M_READ: if (cmd_stb) begin
                    if (int'(cmd_kind) == K_PROG) begin
                        m_pd7 = cmd_d7;
                        if (sec_prot[c]) begin m_st = M_PROT; m_prot = PROT; end
                        else m_st = M_PROG;
                    end else if (int'(cmd_kind) == K_SE) begin
                        m_sel[c] = 1; m_win = WIN; m_st = M_WIN;
                    end else if (int'(cmd_kind) == K_CE) begin
                        foreach (m_sel[i]) m_sel[i] = 1;
                        m_st = M_ERASE;
                    end
                end
                M_PROG: begin
                    if (is_rst) begin m_lim = 0; m_st = M_READ; end
                    else if (alg_limit) m_lim = 1;
                    else if (alg_done && !m_lim) m_st = M_READ;
                end
                M_PROT: begin
                    m_prot--;
                    if (m_prot == 0) m_st = M_READ;
                end
                M_WIN: begin
                    if (cmd_stb) begin
                        if (int'(cmd_kind) == K_SE) begin m_sel[c] = 1; m_win = WIN; end
                        else if (int'(cmd_kind) == K_SUSP) m_st = M_SUSP;
                        else begin foreach (m_sel[i]) m_sel[i] = 0; m_st = M_READ; end
                    end else begin
                        m_win--;
                        if (m_win == 0) m_st = M_ERASE;
                    end
                end
                M_ERASE: begin
                    if (is_rst) begin m_lim = 0; foreach (m_sel[i]) m_sel[i] = 0; m_st = M_READ; end
                    else if (cmd_stb && int'(cmd_kind) == K_SUSP && !m_lim) m_st = M_SUSP;
                    else if (alg_limit) m_lim = 1;
                    else if (alg_done && !m_lim) begin foreach (m_sel[i]) m_sel[i] = 0; m_st = M_READ; end
                end
                M_SUSP: if (cmd_stb) begin
                    if (int'(cmd_kind) == K_RES) m_st = M_ERASE;
                    else if (int'(cmd_kind) == K_PROG && !m_sel[c] && !sec_prot[c]) begin
                        m_pd7 = cmd_d7; m_st = M_SPROG;
                    end
                end
                M_SPROG: begin
                    if (is_rst) begin m_lim = 0; foreach (m_sel[i]) m_sel[i] = 0; m_st = M_READ; end
                    else if (alg_limit) m_lim = 1;
                    else if (alg_done && !m_lim) m_st = M_SUSP;
                end
                default: m_st = M_READ;
            endcase
        end
    end

    task automatic nxt();
        @(posedge clk);
        #1;
        cmd_stb = 0; rd_stb = 0; alg_done = 0; alg_limit = 0;
    endtask

    task automatic cmd(int k, int sec, bit d7);
        cmd_stb = 1; cmd_kind = 3'(k); cmd_sec = SB'(sec); cmd_d7 = d7;
        nxt();
    endtask

    task automatic rd(int sec, logic [7:0] a);
        rd_stb = 1; rd_sec = SB'(sec); arr_data = a;
        nxt();
    endtask

    task automatic rd_alt(int n, int sa, int sb);
        for (int i = 0; i < n; i++) rd(((i % 2) == 0) ? sa : sb, 8'(8'h30 + i));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) nxt();
    endtask

    task automatic done_pulse();
        alg_done = 1;
        nxt();
    endtask

    task automatic lim_pulse();
        alg_limit = 1;
        nxt();
    endtask

    // directed probe with hand-computed expectation, sampled mid-cycle
    task automatic probe(int sec, logic [7:0] a, logic [7:0] exp, bit exp_run, string tag);
        rd_stb = 1; rd_sec = SB'(sec); arr_data = a;
        @(negedge clk);
        checks++;
        if (rd_data !== exp || erase_run !== exp_run) begin
            errors++;
            $display("FAIL %s probe actual %02h/%0b expected %02h/%0b", tag, rd_data, erase_run, exp, exp_run);
        end
        @(posedge clk);
        #1;
        rd_stb = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1;
        // R1: idle reads pass array data
        probe(3, 8'h3C, 8'h3C, 1'b0, "R1");
        rd(0, 8'hFF); rd(9, 8'h00);
        // R2, R11: program with bit7 = 0, then completion
        cmd(K_PROG, 1, 1'b0);
        rd_alt(5, 1, 6);
        idle(2);
        done_pulse();
        probe(1, 8'h11, 8'h11, 1'b0, "R11");
        // R6, R12: limit failure, done ignored, other commands ignored, reset recovers
        cmd(K_PROG, 2, 1'b1);
        rd(2, 8'hAA);
        lim_pulse();
        rd_alt(3, 2, 3);
        done_pulse();
        cmd(K_OTH, 0, 1'b0);
        cmd(K_CE, 0, 1'b0);
        rd(4, 8'h01);
        cmd(K_RST, 0, 1'b0);
        probe(2, 8'hA5, 8'hA5, 1'b0, "R6");
        // R10: program into a protected sector
        sec_prot = 16'h0020;
        cmd(K_PROG, 5, 1'b1);
        rd_alt(4, 5, 0);
        cmd(K_PROG, 1, 1'b0);
        rd_alt(8, 5, 0);
        probe(5, 8'h5E, 8'h5E, 1'b0, "R10");
        // R7, R5: window, retrigger, then erase
        cmd(K_SE, 3, 1'b0);
        rd_alt(10, 3, 4);
        cmd(K_SE, 7, 1'b0);
        rd_alt(30, 7, 4);
        idle(8);
        rd_alt(6, 3, 4);
        idle(10);
        // R3, R4, R5 in erase; R12 program ignored
        rd_alt(6, 7, 0);
        cmd(K_PROG, 0, 1'b0);
        cmd(K_RES, 0, 1'b0);
        rd(0, 8'h42);
        // R9: suspend and suspend-program
        cmd(K_SUSP, 0, 1'b0);
        rd_alt(6, 3, 4);
        probe(4, 8'h66, 8'h66, 1'b0, "R9");
        cmd(K_PROG, 7, 1'b0);
        cmd(K_PROG, 5, 1'b0);
        rd(7, 8'h12);
        cmd(K_PROG, 4, 1'b1);
        rd_alt(5, 4, 3);
        done_pulse();
        rd_alt(4, 3, 4);
        cmd(K_RES, 0, 1'b0);
        rd_alt(6, 7, 2);
        done_pulse();
        probe(7, 8'hFF, 8'hFF, 1'b0, "R11");
        // R8: window abort clears selection
        cmd(K_SE, 1, 1'b0);
        rd(1, 8'h10);
        cmd(K_OTH, 0, 1'b0);
        probe(1, 8'h77, 8'h77, 1'b0, "R8");
        cmd(K_SE, 6, 1'b0);
        cmd(K_PROG, 6, 1'b0);
        rd(6, 8'h01);
        // R8: suspend during window ends it at once
        cmd(K_SE, 2, 1'b0);
        rd(2, 8'h00);
        cmd(K_SUSP, 0, 1'b0);
        rd_alt(4, 2, 1);
        cmd(K_RES, 0, 1'b0);
        rd_alt(4, 2, 1);
        done_pulse();
        // R3: chip erase selects all, limit blocks suspend (R12), reset
        cmd(K_CE, 0, 1'b0);
        rd_alt(6, 9, 14);
        lim_pulse();
        cmd(K_SUSP, 0, 1'b0);
        rd_alt(3, 0, 15);
        cmd(K_RST, 0, 1'b0);
        probe(9, 8'h9A, 8'h9A, 1'b0, "R12");
        // window expiry with no reads
        cmd(K_SE, 0, 1'b0);
        idle(WIN + 3);
        rd(0, 8'h00);
        done_pulse();
        idle(3);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule